// File: doc/BRIEF.md
# Sampling ADC Sequencer with Window Watchdog

This block is the digital control around a 12-bit successive-approximation converter. Software reaches it through a small register bus with one-cycle write and read strobes. A first write of the enable bit brings the converter out of power-down. A later write of the same bit, made while the converter is powered and idle, starts one conversion on the selected channel. There are eighteen selectable channels: sixteen external and two internal.

Each conversion first holds the sample switch closed for a programmable window, counted in half converter-clock units, so that fractional settings such as 55.5 cycles are exact. The block clock runs at twice the converter clock. The successive-approximation search then resolves one bit per converter clock, MSB first. It drives a trial code to the analog core and reads back a single comparator bit. When the result is ready, the block formats it left- or right-aligned into a 16-bit data word and sets an end-of-conversion flag. It also compares the raw code against a high and a low threshold and raises a sticky out-of-window flag.

The analog side is a behavioural comparator outside the block. It answers whether the selected input is at or above the trial code.

Top module: `adc_seq_top`

## Requirements
- R1: After reset the converter is powered down and idle. The end-of-conversion and out-of-window flags are 0, DATA (address 5) reads 0, CTRL (address 0) reads 0, the high threshold (address 2) reads 0x0FFF and the low threshold (address 3) reads 0.
- R2: A CTRL write with the enable bit (bit 0) set and the sleep bit (bit 2) clear, made while powered down, only powers the converter up. No conversion starts.
- R3: The same write, made while powered and idle, starts one conversion. While a conversion is in progress, an enable write has no effect.
- R4: With window value N (address 1, bits 9:0), sampling lasts max(N,1) clocks. It is followed by 12 steps of 2 clocks each, so busy rises at the clock after the start write and the end-of-conversion flag is set N'+24 clocks after the start edge, where N' = max(N,1).
- R5: The search sets trial bits MSB first and keeps each bit when the comparator reports the input at or above the trial code. The result equals the 12-bit level of the selected input.
- R6: The channel field is CTRL bits 12:8. Values 0 to 17 are taken. A write carrying 18 to 31 leaves the previous channel in place, and the other fields of that write still apply.
- R7: CTRL bit 1 selects the alignment. When it is 1, DATA holds the result in bits 15:4 with zeros in bits 3:0. When it is 0, DATA holds the result in bits 11:0 with zeros in bits 15:12.
- R8: The end-of-conversion flag is set when a conversion completes and is cleared by a read of DATA. A completion in the same cycle as that read wins.
- R9: The out-of-window flag is set when a result is above the high threshold or below the low threshold. It then stays set until a write to STATUS (address 4) with bit 1 set clears it. A new out-of-window result in the same cycle wins.
- R10: A CTRL write with the sleep bit set powers the converter down when idle. While a conversion is in progress, the whole write is ignored.
- R11: The channel, alignment and window are captured at the start. Later writes do not affect a conversion in progress.
- R12: STATUS reads bit 0 end-of-conversion, bit 1 out-of-window, bit 2 busy and bit 3 powered. CTRL reads back bit 0 as powered, bit 1 as alignment and bits 12:8 as the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| busy_o | output | 1 | A conversion is in progress |
| pwr_o | output | 1 | Converter is powered up |
| eoc_o | output | 1 | End-of-conversion flag |
| awd_o | output | 1 | Out-of-window flag |
| core_chan | output | 5 | Channel routed to the analog core |
| core_sample | output | 1 | Sample switch closed |
| core_trial | output | 12 | Trial code for the comparator |
| core_ge | input | 1 | Comparator: input is at or above the trial code |

## Verification
The bench goes after the double meaning of the enable bit. A design that started a conversion on the wake-up write, or restarted on an enable written mid-conversion, would show busy at the wrong clock. The sampling count is probed with 55.5 cycles and with a zero setting. An off-by-one in the half-cycle counter, or a zero that stalls the counter, would move the end-of-conversion flag away from the N'+24 clock. The bench also changes the alignment and channel in the middle of a conversion and writes an out-of-range channel. A design without the capture at start, or without the range check, would return a mis-formatted word or the wrong input. It drives results above, below and inside the threshold window to show that the watchdog flag is sticky until it is cleared by writing 1, rather than being cleared by a data read.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int RES_W   = 12;
  localparam int DATA_W  = 16;
  localparam int NUM_CH  = 18;
  localparam int CH_W    = $clog2(NUM_CH);
  localparam int WIN_W   = 10;
  localparam int ADDR_W  = 3;
  localparam int IDX_W   = $clog2(RES_W);
  localparam int PAD_W   = DATA_W - RES_W;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_WINDOW = 3'd1;
  localparam logic [ADDR_W-1:0] A_HIGH   = 3'd2;
  localparam logic [ADDR_W-1:0] A_LOW    = 3'd3;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd4;
  localparam logic [ADDR_W-1:0] A_DATA   = 3'd5;

  localparam int CTRL_EN    = 0;
  localparam int CTRL_LEFT  = 1;
  localparam int CTRL_SLEEP = 2;
  localparam int CTRL_CH    = 8;

  localparam int ST_EOC  = 0;
  localparam int ST_AWD  = 1;
  localparam int ST_BUSY = 2;
  localparam int ST_PWR  = 3;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_SAMPLE = 2'd1,
    SQ_CONV   = 2'd2
  } seq_state_e;

  function automatic logic [DATA_W-1:0] fmt_result(input logic [RES_W-1:0] r,
                                                   input logic left);
    if (left) return {r, {PAD_W{1'b0}}};
    return {{PAD_W{1'b0}}, r};
  endfunction

  function automatic logic outside_window(input logic [RES_W-1:0] r,
                                          input logic [RES_W-1:0] hi,
                                          input logic [RES_W-1:0] lo);
    return (r > hi) || (r < lo);
  endfunction

  function automatic logic [WIN_W-1:0] eff_window(input logic [WIN_W-1:0] w);
    return (w == '0) ? WIN_W'(1) : w;
  endfunction

  function automatic logic [RES_W-1:0] bit_mask(input logic [IDX_W-1:0] idx);
    return RES_W'(1) << idx;
  endfunction

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [DATA_W-1:0] data_fmt,
  input  logic              awd_flag,
  output logic              start_pulse,
  output logic              awd_clear,
  output logic [CH_W-1:0]   chan_next,
  output logic              align_next,
  output logic [WIN_W-1:0]  window,
  output logic [RES_W-1:0]  thr_hi,
  output logic [RES_W-1:0]  thr_lo,
  output logic              pwr,
  output logic              eoc
);

  logic              ctrl_wr;
  logic              en_bit;
  logic              sleep_bit;
  logic [CH_W-1:0]   wr_chan;
  logic              chan_ok;
  logic              wake_pulse;
  logic              sleep_pulse;
  logic              data_rd;

  logic              pwr_q;
  logic              eoc_q;
  logic              align_q;
  logic [CH_W-1:0]   chan_q;
  logic [WIN_W-1:0]  win_q;
  logic [RES_W-1:0]  hi_q;
  logic [RES_W-1:0]  lo_q;
  logic [DATA_W-1:0] data_q;

  assign ctrl_wr     = bus_wr && (bus_addr == A_CTRL);
  assign en_bit      = bus_wdata[CTRL_EN];
  assign sleep_bit   = bus_wdata[CTRL_SLEEP];
  assign wr_chan     = bus_wdata[CTRL_CH +: CH_W];
  assign chan_ok     = (int'(wr_chan) < NUM_CH);
  assign data_rd     = bus_rd && (bus_addr == A_DATA);

  assign wake_pulse  = ctrl_wr && !sleep_bit && en_bit && !pwr_q;
  assign start_pulse = ctrl_wr && !sleep_bit && en_bit && pwr_q && !busy;
  assign sleep_pulse = ctrl_wr && sleep_bit && !busy;
  assign awd_clear   = bus_wr && (bus_addr == A_STATUS) && bus_wdata[ST_AWD];

  // a write is dropped as a whole only when it asks to sleep mid-conversion
  assign chan_next  = (ctrl_wr && chan_ok && !(sleep_bit && busy)) ? wr_chan : chan_q;
  assign align_next = (ctrl_wr && !(sleep_bit && busy)) ? bus_wdata[CTRL_LEFT] : align_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q   <= 1'b0;
      eoc_q   <= 1'b0;
      align_q <= 1'b0;
      chan_q  <= '0;
      win_q   <= '0;
      hi_q    <= '1;
      lo_q    <= '0;
      data_q  <= '0;
    end else begin
      if (sleep_pulse)     pwr_q <= 1'b0;
      else if (wake_pulse) pwr_q <= 1'b1;

      if (done)         eoc_q <= 1'b1;
      else if (data_rd) eoc_q <= 1'b0;

      if (done) data_q <= data_fmt;

      align_q <= align_next;
      chan_q  <= chan_next;

      if (bus_wr && (bus_addr == A_WINDOW)) win_q <= bus_wdata[WIN_W-1:0];
      if (bus_wr && (bus_addr == A_HIGH))   hi_q  <= bus_wdata[RES_W-1:0];
      if (bus_wr && (bus_addr == A_LOW))    lo_q  <= bus_wdata[RES_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[CTRL_EN]          = pwr_q;
        bus_rdata[CTRL_LEFT]        = align_q;
        bus_rdata[CTRL_CH +: CH_W]  = chan_q;
      end
      A_WINDOW: bus_rdata[WIN_W-1:0] = win_q;
      A_HIGH:   bus_rdata[RES_W-1:0] = hi_q;
      A_LOW:    bus_rdata[RES_W-1:0] = lo_q;
      A_STATUS: begin
        bus_rdata[ST_EOC]  = eoc_q;
        bus_rdata[ST_AWD]  = awd_flag;
        bus_rdata[ST_BUSY] = busy;
        bus_rdata[ST_PWR]  = pwr_q;
      end
      A_DATA:   bus_rdata = data_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign window = win_q;
  assign thr_hi = hi_q;
  assign thr_lo = lo_q;
  assign pwr    = pwr_q;
  assign eoc    = eoc_q;

endmodule

// File: rtl/adc_seq_engine.sv
module adc_seq_engine
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CH_W-1:0]   chan_in,
  input  logic              align_in,
  input  logic [WIN_W-1:0]  win_in,
  input  logic              core_ge,
  output logic              busy,
  output logic              done,
  output logic [RES_W-1:0]  result,
  output logic [DATA_W-1:0] data_fmt,
  output logic [CH_W-1:0]   core_chan,
  output logic              core_sample,
  output logic [RES_W-1:0]  core_trial
);

  seq_state_e       state_q;
  logic [WIN_W-1:0] cnt_q;
  logic [WIN_W-1:0] win_lat;
  logic [CH_W-1:0]  chan_lat;
  logic             align_lat;
  logic [IDX_W-1:0] idx_q;
  logic             phase_q;
  logic [RES_W-1:0] acc_q;
  logic             sample_end;
  logic             step_decide;

  assign sample_end  = (state_q == SQ_SAMPLE) && (cnt_q == win_lat);
  assign step_decide = (state_q == SQ_CONV) && phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SQ_IDLE;
      cnt_q     <= '0;
      win_lat   <= '0;
      chan_lat  <= '0;
      align_lat <= 1'b0;
      idx_q     <= '0;
      phase_q   <= 1'b0;
      acc_q     <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          if (start) begin
            state_q   <= SQ_SAMPLE;
            cnt_q     <= WIN_W'(1);
            win_lat   <= eff_window(win_in);
            chan_lat  <= chan_in;
            align_lat <= align_in;
            acc_q     <= '0;
          end
        end
        SQ_SAMPLE: begin
          if (sample_end) begin
            state_q <= SQ_CONV;
            idx_q   <= IDX_W'(RES_W - 1);
            phase_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + WIN_W'(1);
          end
        end
        SQ_CONV: begin
          if (!phase_q) begin
            phase_q <= 1'b1;
          end else begin
            phase_q       <= 1'b0;
            acc_q[idx_q]  <= core_ge;
            if (idx_q == '0) state_q <= SQ_IDLE;
            else             idx_q   <= idx_q - IDX_W'(1);
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy        = (state_q != SQ_IDLE);
  assign done        = step_decide && (idx_q == '0);
  assign result      = acc_q | {{(RES_W-1){1'b0}}, core_ge};
  assign data_fmt    = fmt_result(result, align_lat);
  assign core_chan   = chan_lat;
  assign core_sample = (state_q == SQ_SAMPLE);
  assign core_trial  = (state_q == SQ_CONV) ? (acc_q | bit_mask(idx_q)) : '0;

endmodule

// File: rtl/adc_seq_watch.sv
module adc_seq_watch
  import adc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic [RES_W-1:0] result,
  input  logic [RES_W-1:0] thr_hi,
  input  logic [RES_W-1:0] thr_lo,
  input  logic             clear,
  output logic             out_evt,
  output logic             flag
);

  logic flag_q;

  assign out_evt = done && outside_window(result, thr_hi, thr_lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (out_evt) flag_q <= 1'b1;
    else if (clear)   flag_q <= 1'b0;
  end

  assign flag = flag_q;

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        busy_o,
  output logic        pwr_o,
  output logic        eoc_o,
  output logic        awd_o,
  output logic [4:0]  core_chan,
  output logic        core_sample,
  output logic [11:0] core_trial,
  input  logic        core_ge
);

  logic              start_pulse;
  logic              awd_clear;
  logic [CH_W-1:0]   chan_next;
  logic              align_next;
  logic [WIN_W-1:0]  window;
  logic [RES_W-1:0]  thr_hi;
  logic [RES_W-1:0]  thr_lo;
  logic              busy;
  logic              done;
  logic [RES_W-1:0]  result;
  logic [DATA_W-1:0] data_fmt;
  logic              awd_flag;
  logic              awd_evt;

  adc_seq_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .busy        (busy),
    .done        (done),
    .data_fmt    (data_fmt),
    .awd_flag    (awd_flag),
    .start_pulse (start_pulse),
    .awd_clear   (awd_clear),
    .chan_next   (chan_next),
    .align_next  (align_next),
    .window      (window),
    .thr_hi      (thr_hi),
    .thr_lo      (thr_lo),
    .pwr         (pwr_o),
    .eoc         (eoc_o)
  );

  adc_seq_engine u_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start_pulse),
    .chan_in     (chan_next),
    .align_in    (align_next),
    .win_in      (window),
    .core_ge     (core_ge),
    .busy        (busy),
    .done        (done),
    .result      (result),
    .data_fmt    (data_fmt),
    .core_chan   (core_chan),
    .core_sample (core_sample),
    .core_trial  (core_trial)
  );

  adc_seq_watch u_watch (
    .clk     (clk),
    .rst_n   (rst_n),
    .done    (done),
    .result  (result),
    .thr_hi  (thr_hi),
    .thr_lo  (thr_lo),
    .clear   (awd_clear),
    .out_evt (awd_evt),
    .flag    (awd_flag)
  );

  assign busy_o = busy;
  assign awd_o  = awd_flag;

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
  import adc_seq_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [2:0]  bus_addr,
  input logic [15:0] bus_wdata,
  input logic        busy_o,
  input logic        pwr_o,
  input logic        eoc_o,
  input logic        awd_o,
  input logic [4:0]  core_chan,
  input logic        core_sample,
  input logic        start_evt
);

  logic ctrl_en_wr;
  logic ctrl_sleep_wr;
  logic awd_w1c;

  assign ctrl_en_wr    = bus_wr && (bus_addr == A_CTRL) && bus_wdata[CTRL_EN] && !bus_wdata[CTRL_SLEEP];
  assign ctrl_sleep_wr = bus_wr && (bus_addr == A_CTRL) && bus_wdata[CTRL_SLEEP];
  assign awd_w1c       = bus_wr && (bus_addr == A_STATUS) && bus_wdata[ST_AWD];

  assert_busy_powered_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> pwr_o);

  assert_wake_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en_wr && !pwr_o) |=> (pwr_o && !busy_o));

  assert_start_samples_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (busy_o && core_sample));

  assert_start_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> (!busy_o && pwr_o));

  assert_sample_then_convert_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_sample) |-> busy_o);

  assert_chan_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(core_chan) < NUM_CH);

  assert_done_sets_eoc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> eoc_o);

  assert_awd_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (awd_o && !awd_w1c) |=> awd_o);

  assert_sleep_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_sleep_wr && busy_o) |=> pwr_o);

endmodule

bind adc_seq_top adc_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .busy_o      (busy_o),
  .pwr_o       (pwr_o),
  .eoc_o       (eoc_o),
  .awd_o       (awd_o),
  .core_chan   (core_chan),
  .core_sample (core_sample),
  .start_evt   (start_pulse)
);

// File: tb/sim_adc_seq_top.sv
`timescale 1ns/1ps
module sim_adc_seq_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        busy_o, pwr_o, eoc_o, awd_o, core_sample, core_ge;
  logic [4:0]  core_chan;
  logic [11:0] core_trial;

  logic [11:0] analog [18];
  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  assign core_ge = (core_chan < 5'd18) ? (analog[core_chan] >= core_trial) : 1'b0;

  adc_seq_top u0 (.*);

  // behavioural reference model
  bit m_pwr, m_busy, m_eoc, m_awd, m_left, m_cl, m_fin, m_wasbusy;
  int m_rem, m_ch, m_cch, m_win, m_hi, m_lo, m_data, m_res, m_nch;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pwr = 0; m_busy = 0; m_eoc = 0; m_awd = 0; m_left = 0; m_cl = 0;
      m_rem = 0; m_ch = 0; m_cch = 0; m_win = 0; m_hi = 12'hFFF; m_lo = 0; m_data = 0;
    end else begin
      m_fin = 0;
      m_wasbusy = m_busy;
      if (m_busy) begin
        m_rem = m_rem - 1;
        if (m_rem == 0) begin
          m_busy = 0; m_fin = 1;
          m_res = analog[m_cch];
          m_data = m_cl ? (m_res * 16) : m_res;
        end
      end
      if (bus_rd && bus_addr == 3'd5) m_eoc = 0;
      if (m_fin) m_eoc = 1;
      if (bus_wr && bus_addr == 3'd4 && bus_wdata[1]) m_awd = 0;
      if (m_fin && (m_res > m_hi || m_res < m_lo)) m_awd = 1;
      if (bus_wr) begin
        case (bus_addr)
          3'd0: begin
            if (bus_wdata[2]) begin
              if (!m_wasbusy) begin
                m_pwr = 0;
                m_left = bus_wdata[1];
                if (bus_wdata[12:8] < 18) m_ch = bus_wdata[12:8];
              end
            end else begin
              m_left = bus_wdata[1];
              m_nch = bus_wdata[12:8];
              if (m_nch < 18) m_ch = m_nch;
              if (bus_wdata[0]) begin
                if (!m_pwr) m_pwr = 1;
                else if (!m_wasbusy) begin
                  m_busy = 1;
                  m_rem = ((m_win == 0) ? 1 : m_win) + 24;
                  m_cch = m_ch; m_cl = m_left;
                end
              end
            end
          end
          3'd1: m_win = bus_wdata[9:0];
          3'd2: m_hi = bus_wdata[11:0];
          3'd3: m_lo = bus_wdata[11:0];
          default: ;
        endcase
      end
    end
  end

  function automatic int model_read(input int a);
    case (a)
      0: return (m_ch << 8) | (int'(m_left) << 1) | int'(m_pwr);
      1: return m_win;
      2: return m_hi;
      3: return m_lo;
      4: return (int'(m_pwr) << 3) | (int'(m_busy) << 2) | (int'(m_awd) << 1) | int'(m_eoc);
      5: return m_data;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // compare flags against the model away from the active edge, every clock
  always @(negedge clk) begin
    if (rst_n) begin
      check("R3/R4 busy", busy_o, m_busy);
      check("R2/R10 power", pwr_o, m_pwr);
      check("R8 eoc", eoc_o, m_eoc);
      check("R9 watchdog flag", awd_o, m_awd);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_wr = 1; bus_addr = 3'(a); bus_wdata = 16'(d);
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic rd(input string req, input int a, input int exp);
    int got;
    @(negedge clk);
    bus_rd = 1; bus_addr = 3'(a);
    #1 got = bus_rdata;
    check(req, got, model_read(a));
    check(req, got, exp);
    @(posedge clk); #1;
    bus_rd = 0;
  endtask

  // counts clocks from the start edge until eoc_o is seen
  task automatic measure(input string req, input int exp);
    int n = 0;
    while (!eoc_o && n < 5000) begin
      @(posedge clk); #1 n++;
    end
    check(req, n, exp);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy_o && n < 5000) begin
      @(posedge clk); #1 n++;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog timeout");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 18; i++) analog[i] = 12'(i * 200 + 7);
    analog[3]  = 12'hABC;
    analog[17] = 12'h123;
    analog[4]  = 12'h900;
    analog[5]  = 12'h050;
    analog[6]  = 12'h400;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    rd("R1 ctrl", 0, 0);
    rd("R1 status", 4, 0);
    rd("R1 data", 5, 0);
    rd("R1 high", 2, 12'hFFF);
    rd("R1 low", 3, 0);

    // R4 window of 55.5 cycles = 111 half cycles
    wr(1, 111);
    // R2 wake only
    wr(0, (3 << 8) | 1);
    repeat (5) @(negedge clk);
    check("R2 no start on wake", busy_o, 0);
    rd("R12 status powered", 4, 4'b1000);

    // R3 start, R4 timing, R5 result, R7 right alignment
    wr(0, (3 << 8) | 1);
    measure("R4 eoc after 111+24", 135);
    rd("R5 R7 right aligned", 5, 16'h0ABC);
    rd("R8 eoc cleared", 4, 4'b1000);

    // R7 left alignment, R6 channel 17
    wr(0, (17 << 8) | 2 | 1);
    measure("R6 R7 ch17 timing", 135);
    rd("R7 left aligned", 5, 16'h1230);

    // R6 out-of-range channel keeps 17, R11 change mid-conversion
    wr(0, (20 << 8) | 1);
    rd("R6 channel kept", 0, (17 << 8) | 1);
    repeat (10) @(negedge clk);
    wr(0, (3 << 8) | 2);                 // align/channel change mid-run
    wr(0, (3 << 8) | 2 | 1);             // R3 enable while busy ignored
    wr(0, 4);                            // R10 sleep while busy ignored
    check("R10 still powered", pwr_o, 1);
    wait_idle();
    rd("R11 R3 captured format", 5, 16'h0123);
    rd("R11 channel field", 0, (3 << 8) | 2 | 1);

    // R4 zero window acts as one
    wr(1, 0);
    wr(0, (6 << 8) | 1);
    measure("R4 zero window", 25);
    rd("R5 ch6", 5, 16'h0400);

    // R9 watchdog
    wr(2, 12'h800);
    wr(3, 12'h100);
    wr(1, 5);
    wr(0, (4 << 8) | 1);
    measure("R4 window 5", 29);
    check("R9 above high", awd_o, 1);
    rd("R12 status layout", 4, 4'b1011);
    rd("R9 data read keeps flag", 5, 16'h0900);
    check("R9 flag sticky", awd_o, 1);
    wr(4, 2);
    check("R9 w1c", awd_o, 0);
    wr(0, (6 << 8) | 1);
    wait_idle();
    check("R9 inside window", awd_o, 0);
    wr(0, (5 << 8) | 1);
    wait_idle();
    check("R9 below low", awd_o, 1);
    rd("R8 eoc set", 4, 4'b1011);

    // R10 sleep when idle, then wake only
    wr(0, 4);
    check("R10 powered down", pwr_o, 0);
    wr(0, (5 << 8) | 1);
    @(negedge clk);
    check("R10 R2 wake after sleep", busy_o, 0);
    check("R10 R2 power back", pwr_o, 1);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule